// File: doc/BRIEF.md
# Readback Stream Fault Injector

This block sits inline on a byte-wide stream of configuration readback frames and corrupts chosen bytes on purpose, so that a CRC error-detection circuit further down the stream can be exercised without a real upset. A host loads a 21-bit control word through a serial shift-and-update port that behaves like a boundary-scan data register. The port listens only when the device is in user mode and the 10-bit instruction code that selects it is present. The word sets three things: the kind of fault, the byte offset inside the frame, and the XOR pattern.

A written word is held in a staging register and is not made active straight away. It is copied into the active register only at a frame boundary, on the cycle that accepts the last byte of a frame. The frame that follows is the only one the word can corrupt. The fault is either the byte at the chosen offset alone, or that byte and the one after it, both XORed with the same pattern. Every other byte passes through with one cycle of latency, and the `valid` and `last` markers keep their timing. A one-cycle flag marks the output cycle of the last corrupted byte. A new fault needs a new update.

Top module: `rb_fault_injector`

## Requirements
- R1: While `user_mode` is 1 and `ir_code` is 10'b0000010101, each cycle with `dr_shift` high moves `dr_tdi` into bit 20 of the shift register and moves the other bits down one place. `dr_tdo` always shows bit 0, so a word shifts out LSB first.
- R2: When `user_mode` is 0 or `ir_code` holds any other value, `dr_shift` and `dr_update` do nothing. The shift register, the staged word and `active_cfg` keep their values.
- R3: An accepted update stages the shift register contents. The staged word appears on `active_cfg` only in the cycle after a byte with `in_valid` and `in_last` both high, and that byte must not be the one accepted in the same cycle as the update. `active_cfg` does not change at any other time.
- R4: Control word layout: bits [20:19] are the fault kind, bits [18:8] are the byte offset (0 = first byte of the frame), and bits [7:0] are the XOR pattern. With kind 2'b01, the byte at that offset in the first frame after activation leaves as `in_data ^ pattern`.
- R5: With kind 2'b10, the byte at the offset and the byte at offset+1 are both XORed with the pattern.
- R6: With kind 2'b10 and offset FRAME_LEN-1, only that one byte is corrupted. An offset of FRAME_LEN or more corrupts nothing.
- R7: Kind 2'b00 and kind 2'b11 both mean no corruption.
- R8: Corruption happens only in the first frame after activation. Later frames pass unchanged until another update is activated.
- R9: `out_valid`, `out_last` and `out_data` follow `in_valid`, `in_last` and `in_data` one cycle later.
- R10: `inject_done` is high for one cycle, in the output cycle of the last byte that is corrupted.
- R11: After reset the outputs are 0, `active_cfg` is 0, and nothing is staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| user_mode | input | 1 | Device is in user mode; enables the control port |
| ir_code | input | 10 | Current instruction code |
| dr_shift | input | 1 | Shift one bit into the control shift register |
| dr_tdi | input | 1 | Serial data in |
| dr_update | input | 1 | Stage the shift register contents |
| dr_tdo | output | 1 | Serial data out (bit 0 of the shift register) |
| in_valid | input | 1 | Input byte valid |
| in_last | input | 1 | Input byte is the last byte of its frame |
| in_data | input | 8 | Input stream byte |
| out_valid | output | 1 | Output byte valid |
| out_last | output | 1 | Output byte is the last byte of its frame |
| out_data | output | 8 | Output stream byte, possibly corrupted |
| inject_done | output | 1 | Pulse with the last corrupted byte |
| active_cfg | output | 21 | Active control word, readable at any time |

## Verification
Two things can happen in the same cycle: a host update, and the frame-end byte that activates a staged word. If they coincide, the new word must stay staged until the next boundary. Any fault that is already armed must still corrupt its target byte in that cycle. The bench provokes this directly by pulsing `dr_update` together with the last byte of a frame whose final offset is the armed target. It then checks three things: that byte's corrupted value, the unchanged `active_cfg` one cycle later, and which later frame the new word finally corrupts.

// File: rtl/rbfi_pkg.sv
// Package: shared widths, control-word layout and select code for the
// readback stream fault injector.
package rbfi_pkg;

    localparam int DATA_W = 8;
    localparam int LOC_W  = 11;
    localparam int KIND_W = 2;
    localparam int CFG_W  = KIND_W + LOC_W + DATA_W;
    localparam int IR_W   = 10;

    localparam logic [IR_W-1:0] SEL_CODE = 10'b00_0001_0101;

    typedef enum logic [KIND_W-1:0] {
        INJ_NONE   = 2'b00,
        INJ_SINGLE = 2'b01,
        INJ_DOUBLE = 2'b10,
        INJ_BAD    = 2'b11
    } inj_kind_e;

    typedef struct packed {
        inj_kind_e         kind;
        logic [LOC_W-1:0]  loc;
        logic [DATA_W-1:0] pat;
    } inj_cfg_t;

    // Purpose: number of bytes a fault kind corrupts (0, 1 or 2).
    function automatic int unsigned kind_span(inj_kind_e k);
        case (k)
            INJ_SINGLE: kind_span = 1;
            INJ_DOUBLE: kind_span = 2;
            default:    kind_span = 0;
        endcase
    endfunction

endpackage

// File: rtl/rbfi_dr_port.sv
// Module: rbfi_dr_port
// Serial control port. It is a shift register that loads LSB first, plus an
// update strobe. Both act only while user mode is set and the select code
// is present. Assumes the shift and update strobes are synchronous to clk.
module rbfi_dr_port
    import rbfi_pkg::*;
#(
    parameter int                 WORD_W = CFG_W,
    parameter int                 CODE_W = IR_W,
    parameter logic [CODE_W-1:0]  CODE   = SEL_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_mode,
    input  logic [CODE_W-1:0] ir_code,
    input  logic              shift_en,
    input  logic              tdi,
    input  logic              update,
    output logic              tdo,
    output logic [WORD_W-1:0] sr_q,
    output logic              upd_pulse
);

    logic sel;

    // Purpose: the port is live only in user mode with its own code.
    always_comb begin
        sel = user_mode && (ir_code == CODE);
    end

    // Purpose: shift the serial input into the top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (sel && shift_en) begin
            sr_q <= {tdi, sr_q[WORD_W-1:1]};
        end
    end

    // Purpose: serial output and the gated update strobe.
    always_comb begin
        tdo       = sr_q[0];
        upd_pulse = sel && update;
    end

endmodule

// File: rtl/rbfi_stage.sv
// Module: rbfi_stage
// Holds the staged word and the active word. At a frame boundary a staged
// word becomes active and arms a fault for the next frame. A boundary with
// nothing staged disarms. An update in the boundary cycle stays staged
// for the next boundary.
module rbfi_stage
    import rbfi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     upd_pulse,
    input  inj_cfg_t upd_word,
    input  logic     boundary,
    output inj_cfg_t active_q,
    output logic     armed_q
);

    inj_cfg_t pend_q;
    logic     pend_v_q;

    // Purpose: move the staged word to active at a boundary, then stage updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            active_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            if (boundary) begin
                if (pend_v_q) begin
                    active_q <= pend_q;
                    armed_q  <= (kind_span(pend_q.kind) != 0);
                    pend_v_q <= 1'b0;
                end else begin
                    armed_q  <= 1'b0;
                end
            end
            if (upd_pulse) begin
                pend_q   <= upd_word;
                pend_v_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rbfi_pos.sv
// Module: rbfi_pos
// Byte position counter inside a frame. It counts accepted bytes and clears
// after the last byte, either flagged by the stream or reached by count.
// Assumes frames are at most FRAME_LEN bytes long.
module rbfi_pos #(
    parameter int FRAME_LEN = 256,
    localparam int POS_W    = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    output logic [POS_W-1:0] pos_q
);

    localparam logic [POS_W-1:0] POS_END = POS_W'(FRAME_LEN - 1);

    // Purpose: advance on each accepted byte and clear at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (in_valid) begin
            if (in_last || pos_q == POS_END) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rbfi_xor.sv
// Module: rbfi_xor
// Output register with XOR corruption. A generate loop builds one match
// lane per corrupted byte slot. A lane fires when the position equals
// offset+lane, the slot lies inside the frame and the fault kind reaches
// that lane. Assumes the position counter and the armed state refer to
// the byte on the input.
module rbfi_xor
    import rbfi_pkg::*;
#(
    parameter int FRAME_LEN = 256,
    parameter int POS_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic [POS_W-1:0]  pos,
    input  logic              armed,
    input  inj_cfg_t          cfg,
    output logic              out_valid,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data,
    output logic              inject_done
);

    localparam int LANES = 2;
    localparam int CMP_W = ((LOC_W > POS_W) ? LOC_W : POS_W) + 2;
    localparam logic [CMP_W-1:0] LEN_C = CMP_W'(FRAME_LEN);

    logic [LANES-1:0] lane_hit;
    logic [LANES-1:0] lane_ok;
    logic [CMP_W-1:0] pos_c;
    int unsigned      span;
    logic             hit;
    logic             at_final;

    // Purpose: widen the position and find how many slots the kind covers.
    always_comb begin
        pos_c = CMP_W'(pos);
        span  = kind_span(cfg.kind);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [CMP_W-1:0] tgt;
        // Purpose: target position of this slot, and whether it is usable.
        always_comb begin
            tgt        = CMP_W'(cfg.loc) + CMP_W'(k);
            lane_ok[k] = (span > k) && (tgt < LEN_C);
            lane_hit[k] = lane_ok[k] && (pos_c == tgt);
        end
    end

    // Purpose: any slot matching, and whether it is the last usable slot.
    always_comb begin
        hit      = armed && in_valid && (|lane_hit);
        at_final = lane_ok[1] ? lane_hit[1] : lane_hit[0];
    end

    // Purpose: register the stream one cycle and apply the XOR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_last    <= 1'b0;
            out_data    <= '0;
            inject_done <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_last    <= in_valid && in_last;
            out_data    <= hit ? (in_data ^ cfg.pat) : in_data;
            inject_done <= hit && at_final;
        end
    end

endmodule

// File: rtl/rb_fault_injector.sv
// Module: rb_fault_injector
// Top of the readback stream fault injector. It connects the serial
// control port, the stage/activate logic, the byte position counter and
// the XOR output stage. Assumes one byte per cycle when in_valid is high
// and in_last on the final byte of each frame.
module rb_fault_injector
    import rbfi_pkg::*;
#(
    parameter int FRAME_LEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_mode,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              dr_shift,
    input  logic              dr_tdi,
    input  logic              dr_update,
    output logic              dr_tdo,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data,
    output logic              inject_done,
    output logic [CFG_W-1:0]  active_cfg
);

    localparam int POS_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;

    logic [CFG_W-1:0] dr_sr;
    logic             dr_upd;
    inj_cfg_t         stg_active;
    logic             stg_armed;
    logic [POS_W-1:0] pos;
    logic             boundary;

    // Purpose: a frame boundary is the accepted last byte.
    always_comb begin
        boundary   = in_valid && in_last;
        active_cfg = stg_active;
    end

    rbfi_dr_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .user_mode (user_mode),
        .ir_code   (ir_code),
        .shift_en  (dr_shift),
        .tdi       (dr_tdi),
        .update    (dr_update),
        .tdo       (dr_tdo),
        .sr_q      (dr_sr),
        .upd_pulse (dr_upd)
    );

    rbfi_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_pulse (dr_upd),
        .upd_word  (inj_cfg_t'(dr_sr)),
        .boundary  (boundary),
        .active_q  (stg_active),
        .armed_q   (stg_armed)
    );

    rbfi_pos #(.FRAME_LEN(FRAME_LEN)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .pos_q    (pos)
    );

    rbfi_xor #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_xor (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .in_data     (in_data),
        .pos         (pos),
        .armed       (stg_armed),
        .cfg         (stg_active),
        .out_valid   (out_valid),
        .out_last    (out_last),
        .out_data    (out_data),
        .inject_done (inject_done)
    );

endmodule

// File: rtl/rbfi_chk.sv
// Module: rbfi_chk
// Property checker for rb_fault_injector, attached with bind below.
// Assumes the stream and port inputs are driven between clock edges.
module rbfi_chk
    import rbfi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              user_mode,
    input logic              in_valid,
    input logic              in_last,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_last,
    input logic [DATA_W-1:0] out_data,
    input logic              inject_done,
    input logic [CFG_W-1:0]  active_cfg,
    input logic [CFG_W-1:0]  sr,
    input logic              armed
);

    p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_last_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> out_last);

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !armed) |=> (out_data == $past(in_data)));

    p_done_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inject_done |-> out_valid);

    p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inject_done |=> !inject_done);

    p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> $stable(active_cfg));

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |=> $stable(sr));

    p_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (active_cfg[CFG_W-1 -: 2] == 2'b01 ||
                   active_cfg[CFG_W-1 -: 2] == 2'b10));

endmodule

bind rb_fault_injector rbfi_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .user_mode   (user_mode),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_last    (out_last),
    .out_data    (out_data),
    .inject_done (inject_done),
    .active_cfg  (active_cfg),
    .sr          (dr_sr),
    .armed       (stg_armed)
);

// File: tb/sim_rb_fault_injector.sv
module sim_rb_fault_injector;

    localparam int CLK_PERIOD = 10;
    localparam int FL         = 16;
    localparam logic [9:0] CODE = 10'b00_0001_0101;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        user_mode;
    logic [9:0]  ir_code;
    logic        dr_shift, dr_tdi, dr_update, dr_tdo;
    logic        in_valid, in_last;
    logic [7:0]  in_data;
    logic        out_valid, out_last, inject_done;
    logic [7:0]  out_data;
    logic [20:0] active_cfg;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // bench model state
    logic [20:0] b_sr, b_pend, b_active;
    bit          b_pend_v, b_armed;

    always #(CLK_PERIOD/2) clk = ~clk;

    rb_fault_injector #(.FRAME_LEN(FL)) u0 (
        .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .ir_code(ir_code),
        .dr_shift(dr_shift), .dr_tdi(dr_tdi), .dr_update(dr_update),
        .dr_tdo(dr_tdo), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .out_valid(out_valid), .out_last(out_last),
        .out_data(out_data), .inject_done(inject_done),
        .active_cfg(active_cfg)
    );

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit gate_ok(input logic um, input logic [9:0] code);
        return um && (code == CODE);
    endfunction

    function automatic bit exp_hit(input int p);
        int loc = int'(b_active[18:8]);
        logic [1:0] k = b_active[20:19];
        if (!b_armed) return 0;
        if ((k == 2'b01 || k == 2'b10) && p == loc && loc < FL) return 1;
        if (k == 2'b10 && p == loc + 1 && loc + 1 < FL) return 1;
        return 0;
    endfunction

    function automatic bit exp_done(input int p);
        int loc = int'(b_active[18:8]);
        int fin = (b_active[20:19] == 2'b10 && loc + 1 < FL) ? loc + 1 : loc;
        return exp_hit(p) && p == fin;
    endfunction

    // starts and ends at a negedge
    task automatic shift_word(input logic [20:0] w, input logic um,
                              input logic [9:0] code);
        logic [20:0] rd, ex;
        user_mode = um; ir_code = code;
        for (int i = 0; i < 21; i++) begin
            dr_shift = 1'b1; dr_tdi = w[i];
            #1;
            rd[i] = dr_tdo;
            ex[i] = b_sr[0];
            if (gate_ok(um, code)) b_sr = {w[i], b_sr[20:1]};
            @(negedge clk);
        end
        dr_shift = 1'b0;
        check("R1/R2 tdo stream", 64'(rd), 64'(ex));
        user_mode = 1'b1; ir_code = CODE;
    endtask

    task automatic do_update(input logic um, input logic [9:0] code);
        user_mode = um; ir_code = code; dr_update = 1'b1;
        @(negedge clk);
        dr_update = 1'b0;
        if (gate_ok(um, code)) begin b_pend = b_sr; b_pend_v = 1; end
        user_mode = 1'b1; ir_code = CODE;
    endtask

    task automatic send_frame(input bit upd_last, input bit gaps);
        for (int p = 0; p < FL; p++) begin
            logic [7:0] d = 8'($urandom);
            bit h = exp_hit(p);
            bit dn = exp_done(p);
            logic [7:0] ed = h ? (d ^ b_active[7:0]) : d;
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 1'b0; in_last = 1'b0;
                @(negedge clk);
                check("R9 gap", 64'(out_valid), 64'(0));
            end
            in_valid = 1'b1; in_last = (p == FL - 1); in_data = d;
            if (upd_last && p == FL - 1) dr_update = 1'b1;
            @(negedge clk);
            dr_update = 1'b0;
            check(h ? "R4/R5 byte" : "R8 pass byte",
                  64'({out_valid, out_last, out_data}),
                  64'({1'b1, p == FL - 1, ed}));
            check("R10 done", 64'(inject_done), 64'(dn));
        end
        in_valid = 1'b0; in_last = 1'b0;
        // boundary happened at the last edge
        if (b_pend_v) begin
            b_active = b_pend; b_pend_v = 0;
            b_armed = (b_pend[20:19] == 2'b01 || b_pend[20:19] == 2'b10);
        end else b_armed = 0;
        if (upd_last) begin b_pend = b_sr; b_pend_v = 1; end
        check("R3 active after boundary", 64'(active_cfg), 64'(b_active));
    endtask

    function automatic logic [20:0] mk(input logic [1:0] k, input int loc,
                                       input logic [7:0] v);
        return {k, 11'(loc), v};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; user_mode = 1; ir_code = CODE; dr_shift = 0; dr_tdi = 0;
        dr_update = 0; in_valid = 0; in_last = 0; in_data = 0;
        b_sr = 0; b_pend = 0; b_active = 0; b_pend_v = 0; b_armed = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        check("R11 reset outputs",
              64'({out_valid, out_last, out_data, inject_done, dr_tdo}), 64'(0));
        check("R11 reset active", 64'(active_cfg), 64'(0));

        // R4 single byte, R3 staging, R8 only first frame
        shift_word(mk(2'b01, 3, 8'hA5), 1, CODE);
        do_update(1, CODE);
        repeat (3) @(negedge clk);
        check("R3 not active before boundary", 64'(active_cfg), 64'(0));
        send_frame(0, 0);
        send_frame(0, 0);
        send_frame(0, 1);

        // R5 double adjacent
        shift_word(mk(2'b10, 5, 8'h3C), 1, CODE);
        do_update(1, CODE);
        send_frame(0, 0); send_frame(0, 1);

        // R6 double at frame end
        shift_word(mk(2'b10, FL - 1, 8'hFF), 1, CODE);
        do_update(1, CODE);
        send_frame(0, 0); send_frame(0, 0);

        // R6 offset beyond frame
        shift_word(mk(2'b01, FL + 2, 8'h11), 1, CODE);
        do_update(1, CODE);
        send_frame(0, 0); send_frame(0, 0);

        // R7 invalid and none kinds
        shift_word(mk(2'b11, 2, 8'h77), 1, CODE);
        do_update(1, CODE);
        send_frame(0, 0); send_frame(0, 0);
        shift_word(mk(2'b00, 4, 8'h77), 1, CODE);
        do_update(1, CODE);
        send_frame(0, 0); send_frame(0, 0);

        // R2 gating: shift and update ignored without user mode or code
        shift_word(mk(2'b01, 1, 8'h99), 0, CODE);
        shift_word(mk(2'b01, 1, 8'h99), 1, 10'h015 ^ 10'h200);
        do_update(0, CODE);
        do_update(1, 10'h3FF);
        send_frame(0, 0);
        check("R2 active unchanged", 64'(active_cfg), 64'(b_active));

        // collision: update on the activating/target last byte
        shift_word(mk(2'b01, FL - 1, 8'h5A), 1, CODE);
        do_update(1, CODE);
        send_frame(0, 0);
        shift_word(mk(2'b10, 0, 8'hC3), 1, CODE);
        send_frame(1, 0);
        send_frame(0, 0);
        send_frame(0, 0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [1:0] k = 2'($urandom);
            int loc = int'($urandom % (FL + 2));
            logic [7:0] v = 8'($urandom) | 8'h01;
            bit um = ($urandom % 8) != 0;
            shift_word(mk(k, loc, v), um, CODE);
            do_update(($urandom % 8) != 0, CODE);
            send_frame(($urandom % 4) == 0, 1);
            send_frame(0, 1);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule